// File: doc/BRIEF.md
# Demodulator Register Initialisation Sequencer

This block takes a satellite demodulator from its power-up state to the start of signal acquisition without software involvement. After a one-cycle start strobe it issues an ordered series of register writes on a simple write bus. Each write presents an address, a data byte and a valid flag, and completes when the target returns ready. The opening write enables the demodulator. It also starts a guard interval counted in microsecond ticks.

The sequencer uses that interval to program the tuner. It opens a pass-through gate in the demodulator, streams the tuner bytes out on a byte handshake, and closes the gate again. Only when the guard interval has run out and the gate is shut does it write the soft reset. After the reset it writes a mandatory fixed setting, then the optional AGC settings, the signal parameters, and finally the release command that starts acquisition.

All parameter values and tuner bytes are captured when the start strobe is accepted, so they may change freely while the sequence runs.

Top module: `demod_init_seq`

## Requirements
- R1: After reset, and for as long as no start strobe arrives, `busy_o`, `done_o`, `wr_valid_o` and `tun_valid_o` are all low.
- R2: A start strobe accepted while idle raises `busy_o` in the next cycle. The first write, presented in that same cycle, goes to address 127 with data 0x8C.
- R3: While `wr_valid_o` is high and `wr_ready_i` is low, the next cycle still has `wr_valid_o` high with unchanged address and data. A write completes in a cycle where both are high.
- R4: After the enable write, address 20 receives 0x40 (gate open). The `TUNER_BYTES` tuner bytes then follow on the byte handshake, first byte from `tuner_bytes_i[7:0]` and ascending. Address 20 then receives 0x00 (gate closed). No tuner byte is offered outside the open window.
- R5: The write to address 21 with data 0x80 is not presented until at least `GUARD_US` ticks of `us_tick_i` have been sampled after the cycle in which the enable write completed, and until the gate-close write has completed.
- R6: The write that completes right after the reset write goes to address 49 with data 0x32.
- R7: With `agc_ctl_en_i` high, address 39 receives `agc_ctl_i`. With `agc_ref_en_i` high, address 41 receives `agc_ref_i`, after address 39 if both are enabled. A write whose enable is low is left out of the sequence. Both writes come only after the reset write.
- R8: After the AGC writes come address 22 (`lnb_mode_i`), 23 (`sym_hi_i`), 24 (`sym_lo_i`), 25 (`vit_mode_i`) and 26 (`qpsk_ctl_i`), in that order.
- R9: The last write is data 0x01 to address 27. `done_o` is high for exactly the one cycle after that write completes, and `busy_o` is low in the cycle after that.
- R10: A start strobe while `busy_o` is high is ignored. The running sequence is neither restarted nor repeated.
- R11: Parameter inputs and tuner bytes are captured on the accepted start strobe. Changes during the sequence do not alter any write or tuner byte.
- R12: With an immediately ready bus, the reset write completes exactly two cycles after the later of two events. One is the cycle that samples the last required guard tick. The other is the cycle in which the gate-close write completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, accepted only while idle |
| us_tick_i | input | 1 | One-cycle pulse per microsecond |
| lnb_mode_i | input | 8 | LNB / dish control value for address 22 |
| sym_hi_i | input | 8 | Symbol-rate upper byte for address 23 |
| sym_lo_i | input | 8 | Symbol-rate lower byte for address 24 |
| vit_mode_i | input | 8 | Code-rate selection mask for address 25 |
| qpsk_ctl_i | input | 8 | QPSK control value for address 26 |
| agc_ctl_en_i | input | 1 | Include the AGC control write |
| agc_ctl_i | input | 8 | AGC control value for address 39 |
| agc_ref_en_i | input | 1 | Include the AGC reference write |
| agc_ref_i | input | 8 | AGC reference value for address 41 |
| tuner_bytes_i | input | 8*TUNER_BYTES | Tuner bytes, first byte in the low octet |
| wr_addr_o | output | 7 | Register write address |
| wr_data_o | output | 8 | Register write data |
| wr_valid_o | output | 1 | Write request valid |
| wr_ready_i | input | 1 | Write accepted |
| tun_data_o | output | 8 | Tuner byte |
| tun_valid_o | output | 1 | Tuner byte valid |
| tun_ready_i | input | 1 | Tuner byte accepted |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse after the release write |

## Verification
Two events can fall in the same cycle: the guard interval running out, and the gate-close write completing. The reset write depends on both. The bench slows the tuner handshake over a range of stall lengths, and shifts the phase of the microsecond tick at each one. This moves the close write from before the expiry cycle, through the exact same cycle, to after it. In every run the reset write must complete exactly two cycles after the later of the two events, with at least the guard count of ticks in between. The bench also confirms that at least one run hit the coincident case.

// File: rtl/demod_init_pkg.sv
`timescale 1ns/1ps
package demod_init_pkg;

  localparam int ADDR_W = 7;
  localparam int DATA_W = 8;

  typedef logic [ADDR_W-1:0] reg_addr_t;
  typedef logic [DATA_W-1:0] reg_data_t;

  // register addresses the demodulator decodes
  localparam reg_addr_t A_CFG     = 7'd127;
  localparam reg_addr_t A_PORT    = 7'd20;
  localparam reg_addr_t A_RST     = 7'd21;
  localparam reg_addr_t A_LNB     = 7'd22;
  localparam reg_addr_t A_SYMH    = 7'd23;
  localparam reg_addr_t A_SYML    = 7'd24;
  localparam reg_addr_t A_VIT     = 7'd25;
  localparam reg_addr_t A_QPSK    = 7'd26;
  localparam reg_addr_t A_GO      = 7'd27;
  localparam reg_addr_t A_AGC_CTL = 7'd39;
  localparam reg_addr_t A_AGC_REF = 7'd41;
  localparam reg_addr_t A_FIX49   = 7'd49;

  // fixed data values
  localparam reg_data_t D_CFG       = 8'h8C;
  localparam reg_data_t D_PORT_OPEN = 8'h40;
  localparam reg_data_t D_PORT_SHUT = 8'h00;
  localparam reg_data_t D_RST       = 8'h80;
  localparam reg_data_t D_FIX49     = 8'h32;
  localparam reg_data_t D_GO        = 8'h01;

  typedef enum logic [4:0] {
    ST_IDLE, ST_CFG, ST_OPEN, ST_TUNE, ST_CLOSE, ST_HOLD, ST_RST, ST_FIX49,
    ST_AGC_CTL, ST_AGC_REF, ST_LNB, ST_SYMH, ST_SYML, ST_VIT, ST_QPSK,
    ST_GO, ST_FIN
  } seq_st_e;

  typedef struct packed {
    reg_data_t lnb;
    reg_data_t symh;
    reg_data_t syml;
    reg_data_t vit;
    reg_data_t qpsk;
    reg_data_t agc_ctl;
    reg_data_t agc_ref;
    logic      agc_ctl_en;
    logic      agc_ref_en;
  } sig_param_t;

  // true for steps that present a bus write
  function automatic logic step_writes(seq_st_e s);
    case (s)
      ST_IDLE, ST_TUNE, ST_HOLD, ST_FIN: return 1'b0;
      default:                           return 1'b1;
    endcase
  endfunction

  function automatic reg_addr_t step_addr(seq_st_e s);
    case (s)
      ST_CFG:             return A_CFG;
      ST_OPEN, ST_CLOSE:  return A_PORT;
      ST_RST:             return A_RST;
      ST_FIX49:           return A_FIX49;
      ST_AGC_CTL:         return A_AGC_CTL;
      ST_AGC_REF:         return A_AGC_REF;
      ST_LNB:             return A_LNB;
      ST_SYMH:            return A_SYMH;
      ST_SYML:            return A_SYML;
      ST_VIT:             return A_VIT;
      ST_QPSK:            return A_QPSK;
      ST_GO:              return A_GO;
      default:            return '0;
    endcase
  endfunction

  function automatic reg_data_t step_data(seq_st_e s, sig_param_t p);
    case (s)
      ST_CFG:     return D_CFG;
      ST_OPEN:    return D_PORT_OPEN;
      ST_CLOSE:   return D_PORT_SHUT;
      ST_RST:     return D_RST;
      ST_FIX49:   return D_FIX49;
      ST_AGC_CTL: return p.agc_ctl;
      ST_AGC_REF: return p.agc_ref;
      ST_LNB:     return p.lnb;
      ST_SYMH:    return p.symh;
      ST_SYML:    return p.syml;
      ST_VIT:     return p.vit;
      ST_QPSK:    return p.qpsk;
      ST_GO:      return D_GO;
      default:    return '0;
    endcase
  endfunction

  // step that follows a completed write; optional AGC steps are skipped
  function automatic seq_st_e step_after(seq_st_e s, sig_param_t p);
    case (s)
      ST_CFG:     return ST_OPEN;
      ST_OPEN:    return ST_TUNE;
      ST_CLOSE:   return ST_HOLD;
      ST_RST:     return ST_FIX49;
      ST_FIX49:   return p.agc_ctl_en ? ST_AGC_CTL :
                         (p.agc_ref_en ? ST_AGC_REF : ST_LNB);
      ST_AGC_CTL: return p.agc_ref_en ? ST_AGC_REF : ST_LNB;
      ST_AGC_REF: return ST_LNB;
      ST_LNB:     return ST_SYMH;
      ST_SYMH:    return ST_SYML;
      ST_SYML:    return ST_VIT;
      ST_VIT:     return ST_QPSK;
      ST_QPSK:    return ST_GO;
      ST_GO:      return ST_FIN;
      default:    return ST_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/demod_init_step.sv
`timescale 1ns/1ps
module demod_init_step
  import demod_init_pkg::*;
(
  input  seq_st_e    st_i,
  input  sig_param_t prm_i,
  output logic       is_wr_o,
  output reg_addr_t  addr_o,
  output reg_data_t  data_o,
  output seq_st_e    nxt_o
);

  always_comb begin
    is_wr_o = step_writes(st_i);
    addr_o  = step_addr(st_i);
    data_o  = step_data(st_i, prm_i);
    nxt_o   = step_after(st_i, prm_i);
  end

endmodule

// File: rtl/demod_init_guard.sv
`timescale 1ns/1ps
module demod_init_guard #(
  parameter int GUARD_US = 150
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic tick_i,
  output logic expired_o
);

  localparam int CW = $clog2(GUARD_US + 1);

  logic [CW-1:0] cnt_q;
  logic          armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (arm_i) begin
      cnt_q   <= CW'(GUARD_US);
      armed_q <= 1'b1;
    end else if (tick_i && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired_o = armed_q && (cnt_q == '0);

endmodule

// File: rtl/demod_init_tuner.sv
`timescale 1ns/1ps
module demod_init_tuner #(
  parameter int NBYTES = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en_i,
  input  logic [8*NBYTES-1:0] bytes_i,
  output logic [7:0]          data_o,
  output logic                valid_o,
  input  logic                ready_i,
  output logic                last_o
);

  localparam int IW = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam logic [IW-1:0] LAST_IDX = IW'(NBYTES - 1);

  logic [IW-1:0] idx_q;
  logic          take;

  assign valid_o = en_i;
  assign data_o  = bytes_i[idx_q*8 +: 8];
  assign take    = en_i && ready_i;
  assign last_o  = take && (idx_q == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                idx_q <= '0;
    else if (!en_i || last_o)  idx_q <= '0;
    else if (take)             idx_q <= idx_q + 1'b1;
  end

endmodule

// File: rtl/demod_init_seq.sv
`timescale 1ns/1ps
module demod_init_seq
  import demod_init_pkg::*;
#(
  parameter int GUARD_US    = 150,
  parameter int TUNER_BYTES = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic                     us_tick_i,
  input  logic [7:0]               lnb_mode_i,
  input  logic [7:0]               sym_hi_i,
  input  logic [7:0]               sym_lo_i,
  input  logic [7:0]               vit_mode_i,
  input  logic [7:0]               qpsk_ctl_i,
  input  logic                     agc_ctl_en_i,
  input  logic [7:0]               agc_ctl_i,
  input  logic                     agc_ref_en_i,
  input  logic [7:0]               agc_ref_i,
  input  logic [8*TUNER_BYTES-1:0] tuner_bytes_i,
  output logic [6:0]               wr_addr_o,
  output logic [7:0]               wr_data_o,
  output logic                     wr_valid_o,
  input  logic                     wr_ready_i,
  output logic [7:0]               tun_data_o,
  output logic                     tun_valid_o,
  input  logic                     tun_ready_i,
  output logic                     busy_o,
  output logic                     done_o
);

  localparam int TBW = 8 * TUNER_BYTES;

  seq_st_e        st_q, st_d, step_nxt;
  sig_param_t     prm_q;
  logic [TBW-1:0] tbytes_q;
  logic           step_wr;
  reg_addr_t      step_a;
  reg_data_t      step_d;

  // named internal events, used by the bound checker
  logic wr_ack;
  logic cfg_ack;
  logic rst_ack;
  logic go_ack;
  logic guard_expired;
  logic tune_last;
  logic start_take;

  demod_init_step u_step (
    .st_i    (st_q),
    .prm_i   (prm_q),
    .is_wr_o (step_wr),
    .addr_o  (step_a),
    .data_o  (step_d),
    .nxt_o   (step_nxt)
  );

  demod_init_guard #(.GUARD_US(GUARD_US)) u_guard (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm_i     (cfg_ack),
    .tick_i    (us_tick_i),
    .expired_o (guard_expired)
  );

  demod_init_tuner #(.NBYTES(TUNER_BYTES)) u_tuner (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (st_q == ST_TUNE),
    .bytes_i (tbytes_q),
    .data_o  (tun_data_o),
    .valid_o (tun_valid_o),
    .ready_i (tun_ready_i),
    .last_o  (tune_last)
  );

  assign wr_valid_o = step_wr;
  assign wr_addr_o  = step_a;
  assign wr_data_o  = step_d;
  assign wr_ack     = step_wr && wr_ready_i;
  assign cfg_ack    = wr_ack && (st_q == ST_CFG);
  assign rst_ack    = wr_ack && (st_q == ST_RST);
  assign go_ack     = wr_ack && (st_q == ST_GO);
  assign start_take = (st_q == ST_IDLE) && start_i;
  assign busy_o     = (st_q != ST_IDLE);
  assign done_o     = (st_q == ST_FIN);

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (start_i)       st_d = ST_CFG;
      ST_TUNE: if (tune_last)     st_d = ST_CLOSE;
      ST_HOLD: if (guard_expired) st_d = ST_RST;
      ST_FIN:                     st_d = ST_IDLE;
      default: if (wr_ack)        st_d = step_nxt;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prm_q    <= '0;
      tbytes_q <= '0;
    end else if (start_take) begin
      prm_q.lnb        <= lnb_mode_i;
      prm_q.symh       <= sym_hi_i;
      prm_q.syml       <= sym_lo_i;
      prm_q.vit        <= vit_mode_i;
      prm_q.qpsk       <= qpsk_ctl_i;
      prm_q.agc_ctl    <= agc_ctl_i;
      prm_q.agc_ref    <= agc_ref_i;
      prm_q.agc_ctl_en <= agc_ctl_en_i;
      prm_q.agc_ref_en <= agc_ref_en_i;
      tbytes_q         <= tuner_bytes_i;
    end
  end

endmodule

// File: rtl/demod_init_chk.sv
`timescale 1ns/1ps
module demod_init_chk
  import demod_init_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      start_i,
  input reg_addr_t wr_addr_o,
  input reg_data_t wr_data_o,
  input logic      wr_valid_o,
  input logic      wr_ready_i,
  input logic      tun_valid_o,
  input logic      busy_o,
  input logic      done_o,
  input logic      rst_ack,
  input logic      go_ack,
  input logic      guard_expired
);

  logic port_open;
  logic seen_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_open <= 1'b0;
      seen_rst  <= 1'b0;
    end else begin
      if (wr_valid_o && wr_ready_i && wr_addr_o == A_PORT)
        port_open <= (wr_data_o == D_PORT_OPEN);
      if (!busy_o)      seen_rst <= 1'b0;
      else if (rst_ack) seen_rst <= 1'b1;
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!wr_valid_o && !tun_valid_o && !done_o));

  p_first_cfg_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (wr_valid_o && wr_addr_o == A_CFG && wr_data_o == D_CFG));

  p_hold_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_o && !wr_ready_i) |=> (wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o)));

  p_tuner_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tun_valid_o |-> port_open);

  p_reset_guarded_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_o && wr_addr_o == A_RST) |-> (guard_expired && !port_open));

  p_fix49_next_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_ack |=> (wr_valid_o && wr_addr_o == A_FIX49 && wr_data_o == D_FIX49));

  p_agc_after_rst_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_o && (wr_addr_o == A_AGC_CTL || wr_addr_o == A_AGC_REF)) |-> seen_rst);

  p_done_after_go_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(go_ack));

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o));

  p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o && start_i) |=> busy_o);

endmodule

bind demod_init_seq demod_init_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .start_i       (start_i),
  .wr_addr_o     (wr_addr_o),
  .wr_data_o     (wr_data_o),
  .wr_valid_o    (wr_valid_o),
  .wr_ready_i    (wr_ready_i),
  .tun_valid_o   (tun_valid_o),
  .busy_o        (busy_o),
  .done_o        (done_o),
  .rst_ack       (rst_ack),
  .go_ack        (go_ack),
  .guard_expired (guard_expired)
);

// File: tb/demod_init_seq_tb_top.sv
`timescale 1ns/1ps
module demod_init_seq_tb_top;

  localparam int GUARD = 150;
  localparam int NB    = 5;
  localparam int TICKP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic us_tick = 1'b0;
  logic [7:0] lnb = 0, symh = 0, syml = 0, vit = 0, qpsk = 0, actl = 0, aref = 0;
  logic actl_en = 0, aref_en = 0;
  logic [8*NB-1:0] tbytes = '0;
  logic [6:0] wr_addr;
  logic [7:0] wr_data, tun_data;
  logic wr_valid, tun_valid, busy, done;
  logic wr_ready = 1'b0, tun_ready = 1'b0;

  demod_init_seq #(.GUARD_US(GUARD), .TUNER_BYTES(NB)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .us_tick_i(us_tick),
    .lnb_mode_i(lnb), .sym_hi_i(symh), .sym_lo_i(syml), .vit_mode_i(vit),
    .qpsk_ctl_i(qpsk), .agc_ctl_en_i(actl_en), .agc_ctl_i(actl),
    .agc_ref_en_i(aref_en), .agc_ref_i(aref), .tuner_bytes_i(tbytes),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data), .wr_valid_o(wr_valid),
    .wr_ready_i(wr_ready), .tun_data_o(tun_data), .tun_valid_o(tun_valid),
    .tun_ready_i(tun_ready), .busy_o(busy), .done_o(done)
  );

  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  int wr_delay = 0, tun_delay = 0, tick_phase = 0, tick_base = 0;
  int wcnt = 0, tcnt = 0;

  // logs filled by the monitor
  int log_n, log_a[32], log_d[32], log_c[32], log_gap[32];
  int byte_n, byte_v[16], byte_c[16];
  int done_n, done_c, start_c;
  int since_cfg, exp_c, close_c;
  bit armed;
  int stall_seen, stall_bad;
  bit pv, pr;
  int pa, pd;
  bit hit_same;

  // expected list
  int ex_n, ex_a[32], ex_d[32];

  initial forever #2.5 clk = ~clk;
  initial forever begin @(posedge clk); cyc++; end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // input driver: tick and ready responders, after the active edge
  initial forever begin
    @(posedge clk); #1;
    us_tick = (((cyc - tick_base) % TICKP) == tick_phase);
    if (wr_valid) begin
      if (wcnt >= wr_delay) begin wr_ready = 1'b1; wcnt = 0; end
      else begin wr_ready = 1'b0; wcnt++; end
    end else begin wr_ready = 1'b0; wcnt = 0; end
    if (tun_valid) begin
      if (tcnt >= tun_delay) begin tun_ready = 1'b1; tcnt = 0; end
      else begin tun_ready = 1'b0; tcnt++; end
    end else begin tun_ready = 1'b0; tcnt = 0; end
  end

  // monitor, away from the active edge
  initial forever begin
    @(negedge clk);
    if (pv && !pr) begin
      stall_seen++;
      if (!(wr_valid && int'(wr_addr) == pa && int'(wr_data) == pd)) stall_bad++;
    end
    pv = wr_valid; pr = wr_ready; pa = int'(wr_addr); pd = int'(wr_data);
    if (wr_valid && wr_ready && log_n < 32) begin
      log_a[log_n] = int'(wr_addr); log_d[log_n] = int'(wr_data);
      log_c[log_n] = cyc; log_gap[log_n] = since_cfg; log_n++;
      if (wr_addr == 7'd20 && wr_data == 8'h00) close_c = cyc;
    end
    if (tun_valid && tun_ready && byte_n < 16) begin
      byte_v[byte_n] = int'(tun_data); byte_c[byte_n] = cyc; byte_n++;
    end
    if (done) begin done_n++; done_c = cyc; end
    if (wr_valid && wr_ready && wr_addr == 7'd127) begin
      armed = 1'b1; since_cfg = 0;
    end else if (armed && us_tick) begin
      since_cfg++;
      if (since_cfg == GUARD) exp_c = cyc;
    end
  end

  task automatic clear_logs();
    log_n = 0; byte_n = 0; done_n = 0; done_c = -1;
    since_cfg = 0; exp_c = -1; close_c = -1; armed = 1'b0;
    stall_seen = 0; stall_bad = 0;
  endtask

  task automatic set_params(input bit ce, input bit re, input int seed);
    lnb = 8'h41 ^ 8'(seed); symh = 8'h1B; syml = 8'h80 ^ 8'(seed);
    vit = 8'h04; qpsk = 8'(seed); actl = 8'h01 ^ 8'(seed); aref = 8'h5A;
    actl_en = ce; aref_en = re;
    tbytes = {8'h07, 8'h80, 8'h3E ^ 8'(seed), 8'h11, 8'hC2};
  endtask

  task automatic build_exp();
    ex_n = 0;
    ex_a[ex_n] = 127; ex_d[ex_n] = 8'h8C; ex_n++;
    ex_a[ex_n] = 20;  ex_d[ex_n] = 8'h40; ex_n++;
    ex_a[ex_n] = 20;  ex_d[ex_n] = 8'h00; ex_n++;
    ex_a[ex_n] = 21;  ex_d[ex_n] = 8'h80; ex_n++;
    ex_a[ex_n] = 49;  ex_d[ex_n] = 8'h32; ex_n++;
    if (actl_en) begin ex_a[ex_n] = 39; ex_d[ex_n] = int'(actl); ex_n++; end
    if (aref_en) begin ex_a[ex_n] = 41; ex_d[ex_n] = int'(aref); ex_n++; end
    ex_a[ex_n] = 22; ex_d[ex_n] = int'(lnb);  ex_n++;
    ex_a[ex_n] = 23; ex_d[ex_n] = int'(symh); ex_n++;
    ex_a[ex_n] = 24; ex_d[ex_n] = int'(syml); ex_n++;
    ex_a[ex_n] = 25; ex_d[ex_n] = int'(vit);  ex_n++;
    ex_a[ex_n] = 26; ex_d[ex_n] = int'(qpsk); ex_n++;
    ex_a[ex_n] = 27; ex_d[ex_n] = 1;          ex_n++;
  endtask

  function automatic string req_of(input int a);
    case (a)
      127: return "R2";
      20:  return "R4";
      21:  return "R5";
      49:  return "R6";
      39, 41: return "R7";
      27:  return "R9";
      default: return "R8";
    endcase
  endfunction

  task automatic launch();
    @(posedge clk); #1; start = 1'b1; start_c = cyc;
    @(posedge clk); #1; start = 1'b0;
  endtask

  task automatic wait_done();
    while (done_n == 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check_list(input string tag);
    check(log_n == ex_n, "R7", {tag, " write count"}, log_n, ex_n);
    for (int i = 0; i < ex_n && i < log_n; i++) begin
      check(log_a[i] == ex_a[i], req_of(ex_a[i]), {tag, " address"}, log_a[i], ex_a[i]);
      check(log_d[i] == ex_d[i], req_of(ex_a[i]), {tag, " data"}, log_d[i], ex_d[i]);
    end
  endtask

  task automatic check_bytes(input logic [8*NB-1:0] want);
    check(byte_n == NB, "R4", "tuner byte count", byte_n, NB);
    for (int i = 0; i < NB && i < byte_n; i++) begin
      check(byte_v[i] == int'(want[i*8 +: 8]), "R4", "tuner byte", byte_v[i], int'(want[i*8 +: 8]));
      check(byte_c[i] > log_c[1] && byte_c[i] < log_c[2], "R4", "byte outside window", byte_c[i], log_c[1]);
    end
  endtask

  // R1: quiet after reset
  task automatic t_reset();
    repeat (10) @(negedge clk);
    check(!busy && !done && !wr_valid && !tun_valid, "R1", "outputs after reset",
          {busy, done, wr_valid, tun_valid}, 0);
  endtask

  // R2 R4 R5 R6 R7 R8 R9 with both AGC writes and a ready bus
  task automatic t_full();
    logic [8*NB-1:0] want;
    clear_logs(); set_params(1'b1, 1'b1, 0);
    wr_delay = 0; tun_delay = 0; tick_phase = 1; tick_base = cyc;
    want = tbytes; build_exp();
    launch(); wait_done();
    check_list("full");
    check_bytes(want);
    check(log_c[0] == start_c + 1, "R2", "first write cycle", log_c[0], start_c + 1);
    check(log_gap[3] == GUARD, "R5", "guard ticks before reset", log_gap[3], GUARD);
    check(log_c[3] == exp_c + 2, "R12", "reset after expiry", log_c[3], exp_c + 2);
    check(done_n == 1 && done_c == log_c[log_n-1] + 1, "R9", "done cycle", done_c, log_c[log_n-1] + 1);
    check(!busy && !done, "R9", "busy after done", {busy, done}, 0);
  endtask

  // R3 R7 R10 R11: no AGC, stalled bus, mid-run disturbance
  task automatic t_skip_disturb();
    logic [8*NB-1:0] want;
    clear_logs(); set_params(1'b0, 1'b0, 8'h23);
    wr_delay = 2; tun_delay = 1; tick_phase = 0; tick_base = cyc;
    want = tbytes; build_exp();
    launch();
    repeat (20) @(posedge clk);
    #1;
    set_params(1'b1, 1'b1, 8'h99);          // R11: new values must not be used
    start = 1'b1; @(posedge clk); #1; start = 1'b0;   // R10: ignored
    repeat (300) @(posedge clk);
    #1; start = 1'b1; @(posedge clk); #1; start = 1'b0;
    wait_done();
    check_list("skip");
    check_bytes(want);
    check(log_gap[3] >= GUARD, "R5", "guard ticks with stalls", log_gap[3], GUARD);
    check(stall_seen > 0 && stall_bad == 0, "R3", "held write during stall", stall_bad, 0);
    repeat (60) @(negedge clk);
    check(log_n == ex_n && done_n == 1 && !busy, "R10", "no restart", log_n, ex_n);
  endtask

  // R12: sweep tuner stall and tick phase across the guard expiry
  task automatic t_race();
    int lat;
    hit_same = 1'b0;
    for (int d = 112; d <= 121; d++) begin
      for (int ph = 0; ph < TICKP; ph++) begin
        clear_logs(); set_params(1'b0, 1'b1, d);
        wr_delay = 0; tun_delay = d; tick_phase = ph; tick_base = cyc;
        build_exp();
        launch(); wait_done();
        lat = (exp_c > close_c) ? exp_c : close_c;
        if (exp_c == close_c) hit_same = 1'b1;
        check(log_n == ex_n && log_a[3] == 21, "R12", "reset position", log_a[3], 21);
        check(log_c[3] == lat + 2, "R12", "reset after later event", log_c[3], lat + 2);
        check(log_gap[3] >= GUARD, "R5", "guard ticks in race", log_gap[3], GUARD);
      end
    end
    check(hit_same, "R12", "coincident close and expiry reached", hit_same, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R9 watchdog: actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_full();
    t_skip_disturb();
    t_race();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule